// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor that runs every instruction of a small load/store subset in one clock cycle. The subset has word load, word store, five register-to-register operations (add, subtract, bitwise AND, bitwise OR, signed set-less-than), a branch taken when two registers are equal, and an absolute jump. Instruction storage and data storage are two separate word arrays inside the block, so a fetch and a data access can both happen in the same cycle. A 32-entry register file with two read ports and one write port feeds an ALU. The ALU operation comes from a 4-bit code that a two-level decoder derives from the opcode and, for register-format words, the function field.

Both arrays are filled through a preload port, which is honoured only while reset is held. After reset is released the core fetches from address 0. A debug port shows the current PC and the register write about to commit: the enable, the register number and the data. A bench can then compare each retired instruction with a reference model.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high the PC is held at 0 and a preload word is written to the array chosen by `ld_dmem` (1 = data, 0 = instruction) at word index `ld_addr`. In the first cycle after release, `dbg_pc` reads 0.
- R2: An instruction that is not a taken branch or a jump advances the PC by 4 in the next cycle.
- R3: Opcode 0x00 with function 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs&rt or rs|rt (modulo 2^32) to register rd. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0].
- R4: Opcode 0x00 with function 0x2A writes 1 to rd when rs is less than rt as two's-complement numbers, and 0 otherwise.
- R5: Register 0 always reads as zero. A write aimed at it leaves it zero.
- R6: Opcode 0x23 writes to register rt the data word at byte address rs + sign-extended imm16 [15:0]. The word index is address bits above bit 1.
- R7: Opcode 0x2B stores register rt to the data word at rs + sign-extended imm16 and writes no register. No other instruction changes data storage.
- R8: Opcode 0x04 compares rs and rt. When they are equal the next PC is PC+4+(sign-extended imm16 × 4); otherwise it is PC+4. No register is written.
- R9: Opcode 0x02 sets the next PC to the upper 4 bits of PC+4 concatenated with index [25:0] and two zero bits. No register is written.
- R10: Any other opcode, and opcode 0x00 with any other function code, writes neither a register nor data storage and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| ld_we | input | 1 | Preload write strobe, honoured only during reset |
| ld_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| ld_addr | input | LAW (6 by default) | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Address of the instruction now executing |
| dbg_we | output | 1 | The current instruction writes a register at the next edge |
| dbg_waddr | output | 5 | Destination register number |
| dbg_wdata | output | 32 | Value to be written |

## Verification
The register operations are swept over every ordered pair of eight preloaded operands: zero, one, all ones, the largest and smallest signed values and three irregular words. All five function codes run on each pair, which separates signed from unsigned comparison and exposes carry and borrow errors at the sign boundary. Stores use a negative offset and are read back through loads, and a final load sweep over the low data words exposes stray stores. Taken and untaken branches, a jump over an instruction, a write to register 0 and unsupported opcode and function words each separate a correct next-PC or write-suppression path from a wrong one.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ADD,
        CLS_SUB,
        CLS_FUNCT
    } alu_class_e;

    typedef struct packed {
        logic reg_write;
        logic dst_rd;
        logic imm_b;
        logic mem_write;
        logic load_wb;
        logic branch;
        logic jump;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      opcode;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      funct;
    } insn_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [25:0] idx);
        return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);
    alu_class_e cls;
    alu_op_e    fn_op;
    logic       fn_known;

    always_comb begin
        fn_known = 1'b1;
        unique case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: begin
                fn_op    = ALU_ADD;
                fn_known = 1'b0;
            end
        endcase
    end

    always_comb begin
        ctrl = '0;
        cls  = CLS_ADD;
        case (opcode)
            OPC_REG: begin
                ctrl.reg_write = fn_known;
                ctrl.dst_rd    = 1'b1;
                cls            = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.imm_b     = 1'b1;
                ctrl.load_wb   = 1'b1;
            end
            OPC_STORE: begin
                ctrl.imm_b     = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                cls         = CLS_SUB;
            end
            OPC_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        case (cls)
            CLS_SUB:   alu_op = ALU_SUB;
            CLS_FUNCT: alu_op = fn_op;
            default:   alu_op = ALU_ADD;
        endcase
    end

    // R10: at most one kind of architectural effect per instruction
    always_comb begin
        assert_one_effect_R10: assert ($onehot0({ctrl.reg_write, ctrl.mem_write,
                                                 ctrl.branch, ctrl.jump}))
            else $error("decoder raised more than one effect");
    end

endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

    // R8: the equality flag used by the branch tracks operand equality
    always_comb begin
        if (op == ALU_SUB)
            assert_sub_flag_R8: assert (zero == (a == b))
                else $error("zero flag disagrees with operand equality");
    end

endmodule

// File: rtl/core_regbank.sv
module core_regbank
    import core_pkg::*;
#(
    parameter int NREG = 32,
    parameter int W    = XLEN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREG)-1:0]  ra,
    input  logic [$clog2(NREG)-1:0]  rb,
    output logic [W-1:0]             rda,
    output logic [W-1:0]             rdb,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  wa,
    input  logic [W-1:0]             wd
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rda = regs[ra];
    assign rdb = regs[rb];

    // R5: register 0 reads zero on both ports
    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (rst)
        ((ra == AW'(0)) |-> (rda == '0)) and ((rb == AW'(0)) |-> (rdb == '0)))
        else $error("register 0 read nonzero");

endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic             ld_dmem,
    input  logic [LAW-1:0]   ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    output logic [XLEN-1:0]  dbg_pc,
    output logic             dbg_we,
    output logic [RIDX-1:0]  dbg_waddr,
    output logic [XLEN-1:0]  dbg_wdata
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc, pc4, pc_next, br_dest;
    insn_t           ins;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic [XLEN-1:0] imm_x, rda, rdb, alu_b, alu_y, rd_word, wb_data;
    logic            alu_zero, redirect;
    logic [RIDX-1:0] wdst;

    assign ins = insn_t'(imem[pc[IAW+1:2]]);

    core_decode u_dec (
        .opcode (ins.opcode),
        .funct  (ins.funct),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    core_regbank #(.NREG(1 << RIDX), .W(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (ins.rs),
        .rb  (ins.rt),
        .rda (rda),
        .rdb (rdb),
        .we  (ctrl.reg_write),
        .wa  (wdst),
        .wd  (wb_data)
    );

    assign imm_x = sext16({ins.rd, ins.shamt, ins.funct});
    assign alu_b = ctrl.imm_b ? imm_x : rdb;

    core_alu #(.W(XLEN)) u_alu (
        .a    (rda),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign rd_word = dmem[alu_y[DAW+1:2]];
    assign wb_data = ctrl.load_wb ? rd_word : alu_y;
    assign wdst    = ctrl.dst_rd ? ins.rd : ins.rt;

    assign pc4     = pc + XLEN'(4);
    assign br_dest = pc4 + {imm_x[XLEN-3:0], 2'b00};
    assign redirect = ctrl.jump | (ctrl.branch & alu_zero);

    always_comb begin
        if (ctrl.jump)
            pc_next = jump_dest(pc4, {ins.rs, ins.rt, ins.rd, ins.shamt, ins.funct});
        else if (ctrl.branch && alu_zero)
            pc_next = br_dest;
        else
            pc_next = pc4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_we && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_we && ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (ctrl.mem_write) begin
            dmem[alu_y[DAW+1:2]] <= rdb;
        end
    end

    assign dbg_pc    = pc;
    assign dbg_we    = ctrl.reg_write;
    assign dbg_waddr = wdst;
    assign dbg_wdata = wb_data;

    logic unused_bits;
    assign unused_bits = ^{pc[1:0], alu_y};

    // R1: the PC leaves reset at zero
    assert_pc_from_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0))
        else $error("PC not zero after reset");

    // R2: a non-redirecting instruction steps the PC by one word
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(redirect)) |-> (pc == $past(pc) + XLEN'(4)))
        else $error("PC did not advance by 4");

    // R9: a jump lands on a word-aligned target
    assert_jump_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl.jump)) |-> (pc[1:0] == 2'b00))
        else $error("jump target misaligned");

    // R7: data storage write strobe only for the store opcode
    assert_store_only_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_write |-> (ins.opcode == OPC_STORE))
        else $error("data write from a non-store opcode");

endmodule

// File: tb/sim_rcore_top.sv
`timescale 1ns/1ps
module sim_rcore_top;
    localparam int IW  = 512;
    localparam int DW  = 64;
    localparam int LAW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [LAW-1:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc;
    logic        dbg_we;
    logic [4:0]  dbg_waddr;
    logic [31:0] dbg_wdata;

    always #2 clk = ~clk;

    rcore_top #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_pc(dbg_pc), .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata)
    );

    int n_checks = 0;
    int n_err = 0;

    logic [31:0] prog [IW];
    logic [31:0] m_dm [DW];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;
    int          plen;

    logic        e_we;
    logic [4:0]  e_wa;
    logic [31:0] e_wd;
    string       w_tag;
    string       pc_tag;

    task automatic check(input string tag, input bit ok,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(input int idx);
        return {6'h02, 26'(idx)};
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // Reference step: expected write of the current instruction, then update
    task automatic model_eval();
        logic [31:0] w, a, b, sx, addr, pc4;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        w  = prog[m_pc[10:2]];
        op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; fn = w[5:0];
        a  = m_rf[rs]; b = m_rf[rt];
        sx = {{16{w[15]}}, w[15:0]};
        pc4 = m_pc + 32'd4;
        addr = a + sx;
        e_we = 1'b0; e_wa = '0; e_wd = '0;
        pc_tag = "R2";
        case (op)
            6'h00: begin
                e_we = 1'b1; e_wa = rd;
                w_tag = (rd == 5'd0) ? "R5" : "R3";
                case (fn)
                    6'h20: e_wd = a + b;
                    6'h22: e_wd = a - b;
                    6'h24: e_wd = a & b;
                    6'h25: e_wd = a | b;
                    6'h2A: begin
                        e_wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                        if (rd != 5'd0) w_tag = "R4";
                    end
                    default: begin e_we = 1'b0; w_tag = "R10"; pc_tag = "R10"; end
                endcase
                m_pc = pc4;
            end
            6'h23: begin
                e_we = 1'b1; e_wa = rt; e_wd = m_dm[addr[7:2]];
                w_tag = "R6"; m_pc = pc4;
            end
            6'h2B: begin
                m_dm[addr[7:2]] = b; w_tag = "R7"; m_pc = pc4;
            end
            6'h04: begin
                w_tag = "R8"; pc_tag = "R8";
                m_pc = (a == b) ? pc4 + {sx[29:0], 2'b00} : pc4;
            end
            6'h02: begin
                w_tag = "R9"; pc_tag = "R9";
                m_pc = {pc4[31:28], w[25:0], 2'b00};
            end
            default: begin w_tag = "R10"; pc_tag = "R10"; m_pc = pc4; end
        endcase
        if (e_we && e_wa != 5'd0) m_rf[e_wa] = e_wd;
    endtask

    initial begin
        int n, halt_pc, j_at, sweep_pc;
        logic [31:0] pats [8];
        string prev_tag;
        pats = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h5};
        for (int i = 0; i < DW; i++) m_dm[i] = (i < 8) ? pats[i] : 32'h0;
        m_dm[8] = 32'd64;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < IW; i++) prog[i] = '0;
        plen = 0;

        for (int i = 0; i < 8; i++) emit(enc_i(6'h23, 0, i + 1, 4 * i));
        emit(enc_i(6'h23, 0, 30, 32));
        n = 0;
        for (int a = 1; a <= 8; a++)
            for (int b = 1; b <= 8; b++) begin
                emit(enc_r(a, b, 9 + (n % 20), 6'h20)); n++;
                emit(enc_r(a, b, 9 + (n % 20), 6'h22)); n++;
                emit(enc_r(a, b, 9 + (n % 20), 6'h24)); n++;
                emit(enc_r(a, b, 9 + (n % 20), 6'h25)); n++;
                emit(enc_r(a, b, 9 + (n % 20), 6'h2A)); n++;
            end
        emit(enc_r(1, 2, 0, 6'h20));          // R5: write to r0
        emit(enc_r(0, 3, 29, 6'h20));         // R5: r0 reads zero
        emit(enc_i(6'h2B, 30, 6, -4));        // R7: negative offset store
        emit(enc_i(6'h2B, 30, 7, 0));
        emit(enc_i(6'h23, 0, 31, 60));        // R6
        emit(enc_i(6'h23, 30, 28, 0));
        emit(enc_i(6'h04, 1, 1, 2));          // R8 taken
        emit(enc_r(2, 2, 9, 6'h20));
        emit(enc_r(2, 2, 10, 6'h20));
        emit(enc_i(6'h04, 1, 2, 1));          // R8 not taken
        emit(enc_r(2, 2, 11, 6'h20));
        emit(32'hFC22_0000);                  // R10 unknown opcode
        emit(enc_r(1, 2, 12, 6'h3F));         // R10 unknown function
        j_at = plen;
        emit(enc_j(j_at + 2));                // R9
        emit(enc_r(2, 2, 13, 6'h20));
        sweep_pc = plen;
        for (int k = 0; k <= 16; k++) emit(enc_i(6'h23, 0, 9, 4 * k));
        halt_pc = plen;
        emit(enc_j(halt_pc));

        // Preload while reset is held (R1)
        @(negedge clk);
        ld_we = 1'b1;
        for (int i = 0; i < plen; i++) begin
            ld_dmem = 1'b0; ld_addr = LAW'(i); ld_data = prog[i];
            @(negedge clk);
        end
        for (int i = 0; i < DW; i++) begin
            ld_dmem = 1'b1; ld_addr = LAW'(i); ld_data = m_dm[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        m_pc = 32'h0;
        prev_tag = "R1";
        for (int cyc = 0; cyc < 1000; cyc++) begin
            #1;
            check(prev_tag, dbg_pc == m_pc, {32'h0, dbg_pc}, {32'h0, m_pc});
            if (m_pc == 32'(4 * halt_pc) && cyc > halt_pc) break;
            model_eval();
            if (e_we)
                check(w_tag, dbg_we && dbg_waddr == e_wa && dbg_wdata == e_wd,
                      {26'h0, dbg_we, dbg_waddr, dbg_wdata}, {26'h1, e_wa, e_wd});
            else
                check(w_tag, !dbg_we, {63'h0, dbg_we}, 64'h0);
            prev_tag = pc_tag;
            @(negedge clk);
        end
        check("R9", m_pc == 32'(4 * halt_pc), {32'h0, m_pc}, {32'h0, 32'(4 * halt_pc)});
        if (sweep_pc < 0) $display("unreachable");

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        #(4 * 50000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule